// File: doc/BRIEF.md
# Amplifier Offset Trim Calibration Engine

This block is a hardware sequencer that finds offset trim codes for an amplifier without software in the loop. Each trim code is seven bits wide. Bit 6 is a direction (sign) bit, and bits 5..0 form a magnitude. Calibration runs two passes in a fixed order. The first pass tunes the negative-side trim register and the second tunes the positive-side register. For every trial code the engine waits a settling interval, which is a parameter counted in system clocks. It then asks an external ADC for one conversion and keeps the 10-bit result.

The engine does not look at the full result. It only asks whether the three most significant result bits are all ones, all zeros, or mixed. The first conversion of a pass picks the direction bit. Each later conversion compares that class with the direction bit. The outcome is one of three: move on to the next magnitude bit, close the current pass, or end the whole calibration.

A single start pulse launches a run. Busy stays high for the whole run. At the end the engine clears its calibrate and trim-enable flags, pulses done for one cycle, and holds the trim codes it found until the next run.

Top module: `ofs_trim_cal`

## Requirements
- R1: Synchronous reset sets both trim outputs to the no-trim code 7'h40 (bit 6 = 1, bits 5..0 = 0). Reset also drives busy, done, adc_start, trim_en and both calibrate flags low.
- R2: A start pulse while idle begins the negative pass, with trim_neg loaded to 7'h40. A start pulse while busy is ignored and does not disturb the running sequence.
- R3: The engine raises adc_start only after the active trim code has been stable for at least SETTLE_CYC clocks.
- R4: Each trial code gets exactly one conversion. adc_start is a one-cycle pulse, the engine then waits for adc_done, and it captures adc_data on that cycle.
- R5: On the first evaluation of a pass, result bits 9..7 equal to 000 clear the direction bit (bit 6), and 111 leave it at 1. Any other pattern ends the whole calibration.
- R6: In the negative pass, magnitude bits are set to 1 one at a time, in the order 5, 4, 3, 2, 1, 0, with a settle and a conversion after each.
- R7: In the positive pass, the first evaluation also presets the magnitude to 6'h3F. Magnitude bits are then cleared one at a time in the order 5 down to 0.
- R8: After a step conversion, the result class is compared with the direction bit. All ones with direction 1, or all zeros with direction 0, moves on to the next bit. The opposite pairing closes the current pass. A mixed pattern ends the calibration. A continue after bit 0 also closes the pass.
- R9: The negative pass always runs first, and closing it starts the positive pass with trim_pos loaded to 7'h40. cal_neg is high only during the negative pass, and cal_pos only during the positive pass.
- R10: Busy stays high from the cycle after start until the run ends. done is a single-cycle pulse with busy already low. trim_en and the calibrate flags are cleared at that point. Both trim codes then hold, and trim_pos keeps its earlier value if the positive pass never ran.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Calibration request pulse |
| adc_start_o | output | 1 | One-cycle conversion request to the ADC |
| adc_done_i | input | 1 | ADC conversion complete strobe |
| adc_data_i | input | RES_W (10) | ADC result, valid with adc_done_i |
| trim_neg_o | output | MAG_W+1 (7) | Negative-side trim code: direction bit on top, magnitude below |
| trim_pos_o | output | MAG_W+1 (7) | Positive-side trim code: direction bit on top, magnitude below |
| cal_neg_o | output | 1 | High while the negative pass runs |
| cal_pos_o | output | 1 | High while the positive pass runs |
| trim_en_o | output | 1 | Trim-enable flag, high during a run |
| busy_o | output | 1 | Calibration in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |

## Verification
The bench sweeps the point at which each pass breaks off, for both direction outcomes, from an immediate break up to a run through all six magnitude bits. A design with an off-by-one step counter would show a wrong final code or a wrong conversion count. The bench also places mixed patterns on the first and on later evaluations of each pass. An engine that treated a mixed pattern as "advance" would start the positive pass when it should stop, or would load trim_pos when it should not. At every conversion request the bench compares the presented trim code, the calibrate flags and the settle time against a model of its own. An engine that skipped the settle, set magnitude bits in the wrong order, or forgot the positive-pass preset fails at the first affected trial. A mid-run start pulse checks that a restart cannot reload trim_neg.

// File: rtl/ofs_trim_pkg.sv
package ofs_trim_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_CONV,
    ST_EVAL,
    ST_STEP,
    ST_NEXT,
    ST_FINISH
  } cal_state_e;

  typedef enum logic [1:0] {
    MSB_MIXED,
    MSB_ONES,
    MSB_ZEROS
  } msb_class_e;

  function automatic msb_class_e classify(input logic all_ones, input logic all_zeros);
    if (all_ones)       return MSB_ONES;
    else if (all_zeros) return MSB_ZEROS;
    else                return MSB_MIXED;
  endfunction

endpackage

// File: rtl/ofs_settle_timer.sv
module ofs_settle_timer #(
  parameter int unsigned CYCLES = 131250
) (
  input  logic clk,
  input  logic rst,
  input  logic load_i,
  output logic fire_o
);
  localparam int CW = (CYCLES < 2) ? 1 : $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LOAD_VAL = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          run_q;
  logic          fire_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      run_q  <= 1'b0;
      fire_q <= 1'b0;
    end else begin
      fire_q <= 1'b0;
      if (load_i) begin
        cnt_q <= LOAD_VAL;
        run_q <= 1'b1;
      end else if (run_q) begin
        if (cnt_q == '0) begin
          run_q  <= 1'b0;
          fire_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign fire_o = fire_q;

  // R3: the expiry strobe is a single-cycle pulse
  p_fire_single_r3: assert property (@(posedge clk) disable iff (rst)
    fire_q |=> !fire_q);

endmodule

// File: rtl/ofs_adc_port.sv
module ofs_adc_port #(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_i,
  input  logic             adc_done_i,
  input  logic [RES_W-1:0] adc_data_i,
  output logic             adc_start_o,
  output logic [RES_W-1:0] res_o,
  output logic             res_valid_o
);
  logic             start_q;
  logic             pend_q;
  logic             valid_q;
  logic [RES_W-1:0] res_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= 1'b0;
      pend_q  <= 1'b0;
      valid_q <= 1'b0;
      res_q   <= '0;
    end else begin
      start_q <= 1'b0;
      valid_q <= 1'b0;
      if (req_i) begin
        start_q <= 1'b1;
        pend_q  <= 1'b1;
      end else if (pend_q && adc_done_i) begin
        res_q   <= adc_data_i;
        valid_q <= 1'b1;
        pend_q  <= 1'b0;
      end
    end
  end

  assign adc_start_o = start_q;
  assign res_o       = res_q;
  assign res_valid_o = valid_q;

  // R4: no new request while a conversion is outstanding
  p_req_idle_r4: assert property (@(posedge clk) disable iff (rst)
    req_i |-> !pend_q);

  // R4: a captured result always follows a done strobe
  p_valid_after_done_r4: assert property (@(posedge clk) disable iff (rst)
    valid_q |-> $past(adc_done_i));

endmodule

// File: rtl/ofs_trim_seq.sv
module ofs_trim_seq
  import ofs_trim_pkg::*;
#(
  parameter int MAG_W = 6,
  parameter int TOP_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             settle_fire_i,
  input  logic             res_valid_i,
  input  logic [TOP_W-1:0] res_top_i,
  output logic             settle_load_o,
  output logic             conv_req_o,
  output logic [MAG_W:0]   trim_neg_o,
  output logic [MAG_W:0]   trim_pos_o,
  output logic             cal_neg_o,
  output logic             cal_pos_o,
  output logic             trim_en_o,
  output logic             busy_o,
  output logic             done_o
);
  localparam int SW = $clog2(MAG_W + 1);
  localparam logic [MAG_W:0] NO_TRIM = {1'b1, {MAG_W{1'b0}}};
  localparam logic [SW-1:0]  LAST_STEP = SW'(MAG_W);

  cal_state_e     state_q;
  logic           pass_pos_q;
  logic           first_q;
  logic [SW-1:0]  step_q;
  logic [MAG_W:0] trim_neg_q, trim_pos_q;
  logic           settle_load_q, conv_req_q;
  logic           cal_neg_q, cal_pos_q, trim_en_q, busy_q, done_q;

  msb_class_e     cls;
  logic [MAG_W:0] act_trim, act_next;
  logic           act_we;
  logic [MAG_W-1:0] step_mask;
  logic           keep_going;

  assign cls      = classify(&res_top_i, ~|res_top_i);
  assign act_trim = pass_pos_q ? trim_pos_q : trim_neg_q;

  // one-hot mask of the magnitude bit addressed by the step counter, MSB first
  always_comb begin
    step_mask = '0;
    for (int i = 0; i < MAG_W; i++) begin
      if (step_q == SW'(i)) step_mask[MAG_W-1-i] = 1'b1;
    end
  end

  assign keep_going = (cls == MSB_ONES  &&  act_trim[MAG_W]) ||
                      (cls == MSB_ZEROS && !act_trim[MAG_W]);

  always_comb begin
    act_next = act_trim;
    act_we   = 1'b0;
    if (state_q == ST_EVAL && first_q && cls != MSB_MIXED) begin
      act_next = {cls != MSB_ZEROS, pass_pos_q ? {MAG_W{1'b1}} : {MAG_W{1'b0}}};
      act_we   = 1'b1;
    end else if (state_q == ST_STEP && step_q != LAST_STEP) begin
      act_next = pass_pos_q ? (act_trim & ~{1'b0, step_mask})
                            : (act_trim |  {1'b0, step_mask});
      act_we   = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= ST_IDLE;
      pass_pos_q    <= 1'b0;
      first_q       <= 1'b0;
      step_q        <= '0;
      trim_neg_q    <= NO_TRIM;
      trim_pos_q    <= NO_TRIM;
      settle_load_q <= 1'b0;
      conv_req_q    <= 1'b0;
      cal_neg_q     <= 1'b0;
      cal_pos_q     <= 1'b0;
      trim_en_q     <= 1'b0;
      busy_q        <= 1'b0;
      done_q        <= 1'b0;
    end else begin
      settle_load_q <= 1'b0;
      conv_req_q    <= 1'b0;
      done_q        <= 1'b0;

      if (act_we) begin
        if (pass_pos_q) trim_pos_q <= act_next;
        else            trim_neg_q <= act_next;
      end

      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            trim_neg_q    <= NO_TRIM;
            pass_pos_q    <= 1'b0;
            first_q       <= 1'b1;
            step_q        <= '0;
            settle_load_q <= 1'b1;
            cal_neg_q     <= 1'b1;
            trim_en_q     <= 1'b1;
            busy_q        <= 1'b1;
            state_q       <= ST_SETTLE;
          end
        end
        ST_SETTLE: begin
          if (settle_fire_i) begin
            conv_req_q <= 1'b1;
            state_q    <= ST_CONV;
          end
        end
        ST_CONV: begin
          if (res_valid_i) state_q <= ST_EVAL;
        end
        ST_EVAL: begin
          if (cls == MSB_MIXED) begin
            state_q <= ST_FINISH;
          end else if (first_q) begin
            first_q <= 1'b0;
            step_q  <= '0;
            state_q <= ST_STEP;
          end else if (keep_going) begin
            step_q  <= step_q + 1'b1;
            state_q <= ST_STEP;
          end else begin
            state_q <= ST_NEXT;
          end
        end
        ST_STEP: begin
          if (step_q == LAST_STEP) begin
            state_q <= ST_NEXT;
          end else begin
            settle_load_q <= 1'b1;
            state_q       <= ST_SETTLE;
          end
        end
        ST_NEXT: begin
          if (!pass_pos_q) begin
            pass_pos_q    <= 1'b1;
            trim_pos_q    <= NO_TRIM;
            first_q       <= 1'b1;
            step_q        <= '0;
            cal_neg_q     <= 1'b0;
            cal_pos_q     <= 1'b1;
            settle_load_q <= 1'b1;
            state_q       <= ST_SETTLE;
          end else begin
            state_q <= ST_FINISH;
          end
        end
        ST_FINISH: begin
          cal_neg_q <= 1'b0;
          cal_pos_q <= 1'b0;
          trim_en_q <= 1'b0;
          busy_q    <= 1'b0;
          done_q    <= 1'b1;
          state_q   <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign settle_load_o = settle_load_q;
  assign conv_req_o    = conv_req_q;
  assign trim_neg_o    = trim_neg_q;
  assign trim_pos_o    = trim_pos_q;
  assign cal_neg_o     = cal_neg_q;
  assign cal_pos_o     = cal_pos_q;
  assign trim_en_o     = trim_en_q;
  assign busy_o        = busy_q;
  assign done_o        = done_q;

  // R6: the negative pass only ever sets magnitude bits
  p_neg_mag_grow_r6: assert property (@(posedge clk) disable iff (rst)
    (cal_neg_q && $past(cal_neg_q)) |->
      ((~trim_neg_q[MAG_W-1:0] & $past(trim_neg_q[MAG_W-1:0])) == '0));

  // R7: after the preset, the positive pass only ever clears magnitude bits
  p_pos_mag_shrink_r7: assert property (@(posedge clk) disable iff (rst)
    (cal_pos_q && $past(cal_pos_q) && !$past(first_q)) |->
      ((trim_pos_q[MAG_W-1:0] & ~$past(trim_pos_q[MAG_W-1:0])) == '0));

  // R9: at most one pass flag at a time
  p_cal_excl_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cal_neg_q, cal_pos_q}));

  // R10: busy holds until the finishing state
  p_busy_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (busy_q && state_q != ST_FINISH) |=> busy_q);

  // R10: done is a lone pulse seen with the run flags already cleared
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
  p_done_idle_r10: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (!busy_q && !trim_en_q && !cal_neg_q && !cal_pos_q));

endmodule

// File: rtl/ofs_trim_cal.sv
module ofs_trim_cal #(
  parameter int          MAG_W      = 6,
  parameter int          RES_W      = 10,
  parameter int          TOP_W      = 3,
  parameter int unsigned SETTLE_CYC = 131250
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  output logic             adc_start_o,
  input  logic             adc_done_i,
  input  logic [RES_W-1:0] adc_data_i,
  output logic [MAG_W:0]   trim_neg_o,
  output logic [MAG_W:0]   trim_pos_o,
  output logic             cal_neg_o,
  output logic             cal_pos_o,
  output logic             trim_en_o,
  output logic             busy_o,
  output logic             done_o
);
  logic             settle_load, settle_fire;
  logic             conv_req, res_valid;
  logic [RES_W-1:0] res_word;

  ofs_settle_timer #(.CYCLES(SETTLE_CYC)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .load_i (settle_load),
    .fire_o (settle_fire)
  );

  ofs_adc_port #(.RES_W(RES_W)) u_adc (
    .clk         (clk),
    .rst         (rst),
    .req_i       (conv_req),
    .adc_done_i  (adc_done_i),
    .adc_data_i  (adc_data_i),
    .adc_start_o (adc_start_o),
    .res_o       (res_word),
    .res_valid_o (res_valid)
  );

  ofs_trim_seq #(.MAG_W(MAG_W), .TOP_W(TOP_W)) u_seq (
    .clk           (clk),
    .rst           (rst),
    .start_i       (start_i),
    .settle_fire_i (settle_fire),
    .res_valid_i   (res_valid),
    .res_top_i     (res_word[RES_W-1 -: TOP_W]),
    .settle_load_o (settle_load),
    .conv_req_o    (conv_req),
    .trim_neg_o    (trim_neg_o),
    .trim_pos_o    (trim_pos_o),
    .cal_neg_o     (cal_neg_o),
    .cal_pos_o     (cal_pos_o),
    .trim_en_o     (trim_en_o),
    .busy_o        (busy_o),
    .done_o        (done_o)
  );

  // R1: right after reset the engine is idle with both codes at no-trim
  p_reset_state_r1: assert property (@(posedge clk)
    $past(rst) |-> (!busy_o && !adc_start_o && trim_neg_o == {1'b1, {MAG_W{1'b0}}}
                    && trim_pos_o == {1'b1, {MAG_W{1'b0}}}));

endmodule

// File: tb/ofs_trim_cal_test.sv
module ofs_trim_cal_test;
  localparam int SETTLE = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic       adc_done = 1'b0;
  logic [9:0] adc_data = '0;
  logic       adc_start, cal_neg, cal_pos, trim_en, busy, done;
  logic [6:0] trim_neg, trim_pos;

  always #4 clk = ~clk;

  ofs_trim_cal #(.MAG_W(6), .RES_W(10), .TOP_W(3), .SETTLE_CYC(SETTLE)) uut (
    .clk(clk), .rst(rst), .start_i(start), .adc_start_o(adc_start),
    .adc_done_i(adc_done), .adc_data_i(adc_data), .trim_neg_o(trim_neg),
    .trim_pos_o(trim_pos), .cal_neg_o(cal_neg), .cal_pos_o(cal_pos),
    .trim_en_o(trim_en), .busy_o(busy), .done_o(done));

  int errs = 0;
  int checks = 0;

  // result classes: 0 = top bits 111, 1 = top bits 000, 2 = mixed
  int         cls [14];
  logic [6:0] exp_trim [14];
  logic       exp_pos [14];
  int         exp_conv;
  logic [6:0] exp_tn, exp_tp;
  int         conv_idx, dones, busy_gap, lat, stab;
  logic       in_run;
  logic [6:0] prev_act;
  logic       prev_pos;
  logic [9:0] pend_data;
  logic [31:0] rng = 32'h1234_5678;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] x = s;
    x ^= x << 13; x ^= x >> 17; x ^= x << 5;
    return x;
  endfunction

  task automatic build_model();
    int n = 0;
    logic [6:0] t;
    bit stop = 0;
    for (int p = 0; p < 2 && !stop; p++) begin
      t = 7'h40;
      exp_trim[n] = t; exp_pos[n] = (p == 1);
      if (cls[n] == 2) begin
        stop = 1; n++;
      end else begin
        t[6] = (cls[n] == 0);
        t[5:0] = (p == 1) ? 6'h3F : 6'h00;
        n++;
        for (int k = 0; k < 6; k++) begin
          if (p == 0) t[5-k] = 1'b1; else t[5-k] = 1'b0;
          exp_trim[n] = t; exp_pos[n] = (p == 1);
          if (cls[n] == 2) begin stop = 1; n++; break; end
          if (!((cls[n] == 0 && t[6]) || (cls[n] == 1 && !t[6]))) begin n++; break; end
          n++;
        end
      end
      if (p == 0) exp_tn = t; else exp_tp = t;
    end
    exp_conv = n;
  endtask

  // single monitor / ADC model, sampling at the falling edge
  initial begin
    lat = 0; stab = 0; prev_act = '0; prev_pos = 0;
    forever begin
      @(negedge clk);
      if ((cal_pos ? trim_pos : trim_neg) == prev_act && cal_pos == prev_pos) stab++;
      else stab = 0;
      prev_act = cal_pos ? trim_pos : trim_neg;
      prev_pos = cal_pos;
      if (in_run && !busy && !done) busy_gap++;
      if (done) begin
        dones++; in_run = 0;
        chk(!busy && !trim_en, "R10 done with busy/trim_en low", {busy, trim_en}, 0);
      end
      if (adc_done) adc_done = 1'b0;
      if (lat > 0) begin
        lat--;
        if (lat == 0) begin adc_done = 1'b1; adc_data = pend_data; end
      end
      if (adc_start) begin
        chk(conv_idx < exp_conv, "R4 conversion count", conv_idx + 1, exp_conv);
        if (conv_idx < 14) begin
          chk((cal_pos ? trim_pos : trim_neg) == exp_trim[conv_idx], "R6/R7 trial code",
              cal_pos ? trim_pos : trim_neg, exp_trim[conv_idx]);
          chk(cal_pos == exp_pos[conv_idx] && cal_neg == !exp_pos[conv_idx],
              "R9 pass flags", {cal_neg, cal_pos}, {!exp_pos[conv_idx], exp_pos[conv_idx]});
          rng = nxt(rng);
          case (cls[conv_idx])
            0: pend_data = {3'b111, rng[6:0]};
            1: pend_data = {3'b000, rng[6:0]};
            default: pend_data = {3'(1 + (rng[15:8] % 6)), rng[6:0]};
          endcase
        end
        chk(stab >= SETTLE, "R3 settle before request", stab, SETTLE);
        lat = 1 + (conv_idx % 3);
        conv_idx++;
      end
    end
  end

  task automatic run_case(input int restart_at, input string tag);
    logic [6:0] hn, hp;
    build_model();
    conv_idx = 0; dones = 0; busy_gap = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0; in_run = 1;
    chk(busy && cal_neg && trim_en && trim_neg == 7'h40, "R2 start loads neg pass",
        {busy, cal_neg, trim_en, trim_neg}, {3'b111, 7'h40});
    for (int c = 0; c < 4000 && dones == 0; c++) begin
      @(negedge clk);
      start = (c == restart_at);
    end
    start = 1'b0;
    repeat (6) @(negedge clk);
    chk(dones == 1, {"R10 single done ", tag}, dones, 1);
    chk(conv_idx == exp_conv, {"R4 conversions ", tag}, conv_idx, exp_conv);
    chk(trim_neg == exp_tn, {"R6 final neg code ", tag}, trim_neg, exp_tn);
    chk(trim_pos == exp_tp, {"R7 final pos code ", tag}, trim_pos, exp_tp);
    chk(busy_gap == 0, {"R10 busy held ", tag}, busy_gap, 0);
    chk(!cal_neg && !cal_pos && !trim_en && !busy, {"R10 flags cleared ", tag},
        {cal_neg, cal_pos, trim_en, busy}, 0);
    hn = trim_neg; hp = trim_pos;
    repeat (5) @(negedge clk);
    chk(trim_neg == hn && trim_pos == hp, {"R10 codes hold ", tag}, {trim_neg, trim_pos}, {hn, hp});
  endtask

  task automatic fill(input int v);
    for (int i = 0; i < 14; i++) cls[i] = v;
  endtask

  initial begin
    in_run = 0; exp_tp = 7'h40;
    repeat (4) @(negedge clk);
    chk(trim_neg == 7'h40 && trim_pos == 7'h40, "R1 reset codes", {trim_neg, trim_pos}, {7'h40, 7'h40});
    chk(!busy && !done && !adc_start && !trim_en && !cal_neg && !cal_pos, "R1 reset flags",
        {busy, done, adc_start, trim_en, cal_neg, cal_pos}, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    // R8 all ones: both passes run all six bits
    fill(0); run_case(-1, "ones");
    // R8 all zeros
    fill(1); run_case(-1, "zeros");
    // R5 mixed on first evaluation: run ends, trim_pos untouched
    fill(0); cls[0] = 2; run_case(-1, "mixed-first");
    // R5 mixed on first evaluation of the positive pass
    fill(1); cls[1] = 0; cls[2] = 2; run_case(-1, "mixed-pos-first");
    // R8 mixed mid negative pass
    fill(0); cls[3] = 2; run_case(-1, "mixed-mid");
    // R2 restart attempt while busy is ignored
    fill(0); cls[4] = 1; run_case(3, "restart-ignored");

    // R8 sweep of break point for both direction outcomes
    for (int d = 0; d < 2; d++) begin
      for (int j = 0; j < 7; j++) begin
        fill(d);
        if (j < 6) cls[1 + j] = 1 - d;
        for (int i = 0; i < 14; i++) if (i > j + 1) cls[i] = 1 - d;
        if (j < 6) begin
          cls[j + 2] = 1 - d;
          for (int i = j + 3; i < 14; i++) cls[i] = (i - j - 3 < j) ? 1 - d : d;
        end
        run_case(-1, $sformatf("sweep d%0d j%0d", d, j));
      end
    end

    // R5 R8 pseudo-random class sequences
    for (int r = 0; r < 40; r++) begin
      for (int i = 0; i < 14; i++) begin
        rng = nxt(rng);
        cls[i] = (rng[2:0] == 3'd0) ? 2 : int'(rng[3]);
      end
      run_case((r % 5 == 0) ? 2 : -1, $sformatf("rand %0d", r));
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule